// File: doc/BRIEF.md
# Fan Control I2C Target

This block is a register target on a two-wire I2C bus that lets a host set fan speeds and read them back. Three main fans each get a PWM output whose duty cycle is set in whole percent. Each of these fans also has a tachometer input. The block counts tachometer pulses over a fixed window of one second and reports the count as revolutions per second.

A single control byte switches the three main fans and five module fans on and off. A module fan is switched on only while its module reports that it is present. A read and a write to the same register index reach different storage: a write to index 1 to 3 sets a duty cycle, and a read of that index returns the measured speed.

The bus pins are modelled as an open-drain pair. The target watches the bus level on `sclIn` and `sdaIn`, and it pulls the data line low only through `sdaDriveLow`. The target never stretches the clock and does not take part in arbitration.

Top module: `fan_ctrl_target`

## Requirements
- R1: Only the 7-bit address `TARGET_ADDR` (default 0x74) is acknowledged. Address bit 0 of the first byte after a start is 0 for a write and 1 for a read, and bits go most significant first. A transfer to any other address gets no acknowledge, and the bytes that follow change nothing. The data line is never pulled or released while the clock is high.
- R2: The byte after the address is a register index. Indices 0 to 3 are acknowledged and become the current register. Any index of 4 or more is not acknowledged, and the data byte that follows is ignored.
- R3: After reset the control byte is 0xFF and all three duty cycles are 30.
- R4: Writing index 0 stores the data byte as the control byte, and reading index 0 returns it.
- R5: Writing index 1, 2 or 3 sets the duty of fan 1, 2 or 3, which drives `pwmOut[0]`, `[1]` or `[2]`. A PWM period is 100 steps of `PWM_PRESCALE` clocks each. The output is high for exactly `duty` steps of every period, and each fan is independent of the others.
- R6: A written duty above 100 is stored as 100, so the output is high for the whole period.
- R7: Reading index 1, 2 or 3 returns the number of rising edges on `tachIn[0]`, `[1]` or `[2]` in the last completed window of `TACH_WINDOW` clocks. The count saturates at 255.
- R8: `mainFanEn[i]` follows bit i of the control byte, for i from 0 to 2.
- R9: `modFanEn[j]` is high only when control bit 3+j is set and `modPresent[j]` is high. Positions j=0..3 are modules B, C, D and E, and j=4 is the shared fan of modules A and F.
- R10: In a read, every byte sent comes from the current register. A master acknowledge asks for another byte, and a master no-acknowledge ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level (wired-AND of all drivers) |
| sdaDriveLow | output | 1 | High to pull the data line low |
| tachIn | input | 3 | Tachometer pulses of fans 1 to 3 |
| modPresent | input | 5 | Module present flags: B, C, D, E, A/F |
| pwmOut | output | 3 | PWM drive of fans 1 to 3 |
| mainFanEn | output | 3 | Enables of fans 1 to 3 |
| modFanEn | output | 5 | Module fan enables, gated by presence |

## Verification
The duty path is driven through a write of each edge value: 0, 1, 2, the midpoint, 99, 100 and several values above 100. For each one the bench counts high cycles over a whole PWM period. This separates an off-by-one in the step compare from a missing clamp, and it also catches a write that reaches the wrong fan.

Every upper control pattern is crossed with every presence pattern. This shows whether the module enables gate on presence, mirror the control bits, or map to the wrong position.

Tachometer trains whose periods divide the window exactly yield counts of 0, 50, 100, 200 and 250, plus one train that overflows. These counts tell the per-window count apart from saturation. Foreign addresses and out-of-range indices are followed by reads and PWM counts, which show that nothing was written.

// File: rtl/fanreg_pkg.sv
package fanreg_pkg;

  localparam int NUM_FANS = 3;
  localparam int NUM_MODS = 5;
  localparam int NUM_REGS = 4;
  localparam int PWM_STEPS = 100;

  localparam logic [7:0] DUTY_FULL  = 8'd100;
  localparam logic [7:0] DUTY_RESET = 8'd30;
  localparam logic [7:0] CTRL_RESET = 8'hFF;
  localparam logic [7:0] TACH_SAT   = 8'hFF;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       wrStb;
    logic [1:0] regSel;
    logic [7:0] wrByte;
  } regCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } busState_e;

endpackage

// File: rtl/fan_i2c_ctrl.sv
module fan_i2c_ctrl
  import fanreg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h74
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output regCmd_t    cmd,
  output logic       sdaDriveLow
);

  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow;
  logic       sclRise, sclFall, startSeen, stopSeen;

  busState_e  state;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic       isRead, masterAck;
  logic [1:0] regPtr;
  logic       wrStb;
  logic [7:0] wrByte;
  logic       sdaLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      regPtr    <= '0;
      wrStb     <= 1'b0;
      wrByte    <= '0;
      sdaLow    <= 1'b0;
    end else begin
      wrStb <= 1'b0;
      if (startSeen) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopSeen) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else begin
        if (sclRise) begin
          rxShift <= {rxShift[6:0], sdaNow};
          if (bitCnt != BYTE_BITS) bitCnt <= bitCnt + 4'd1;
          if (state == ST_RD_ACK) masterAck <= ~sdaNow;
        end
        if (sclFall) begin
          unique case (state)
            ST_ADDR: if (bitCnt == BYTE_BITS) begin
              bitCnt <= '0;
              if (rxShift[7:1] == TARGET_ADDR) begin
                sdaLow <= 1'b1;
                isRead <= rxShift[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADDR_ACK: begin
              bitCnt <= '0;
              if (isRead) begin
                txShift <= rdByte;
                sdaLow  <= ~rdByte[7];
                state   <= ST_RD;
              end else begin
                sdaLow <= 1'b0;
                state  <= ST_REG;
              end
            end
            ST_REG: if (bitCnt == BYTE_BITS) begin
              bitCnt <= '0;
              if (rxShift < REG_LIMIT) begin
                regPtr <= rxShift[1:0];
                sdaLow <= 1'b1;
                state  <= ST_REG_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_REG_ACK, ST_WR_ACK: begin
              sdaLow <= 1'b0;
              bitCnt <= '0;
              state  <= ST_WR;
            end
            ST_WR: if (bitCnt == BYTE_BITS) begin
              bitCnt <= '0;
              wrStb  <= 1'b1;
              wrByte <= rxShift;
              sdaLow <= 1'b1;
              state  <= ST_WR_ACK;
            end
            ST_RD: begin
              if (bitCnt == BYTE_BITS) begin
                sdaLow <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
                sdaLow  <= ~txShift[6];
              end
            end
            ST_RD_ACK: begin
              bitCnt <= '0;
              if (masterAck) begin
                txShift <= rdByte;
                sdaLow  <= ~rdByte[7];
                state   <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign cmd         = '{wrStb: wrStb, regSel: regPtr, wrByte: wrByte};
  assign sdaDriveLow = sdaLow;

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fanreg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tachIn,
  input  logic       windowEnd,
  output logic [7:0] rps
);

  logic [1:0] tachSync;
  logic       tachPrev;
  logic       tachEdge;
  logic [7:0] edgeCnt;
  logic [7:0] edgeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tachSync <= '0;
      tachPrev <= 1'b0;
    end else begin
      tachSync <= {tachSync[0], tachIn};
      tachPrev <= tachSync[1];
    end
  end

  assign tachEdge = tachSync[1] & ~tachPrev;
  assign edgeNext = (tachEdge && edgeCnt != TACH_SAT) ? edgeCnt + 8'd1 : edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      rps     <= '0;
    end else if (windowEnd) begin
      rps     <= edgeNext;
      edgeCnt <= '0;
    end else begin
      edgeCnt <= edgeNext;
    end
  end

endmodule

// File: rtl/fan_datapath.sv
module fan_datapath
  import fanreg_pkg::*;
#(
  parameter int PWM_PRESCALE = 250,
  parameter int TACH_WINDOW  = 25_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  regCmd_t             cmd,
  input  logic [NUM_FANS-1:0] tachIn,
  input  logic [NUM_MODS-1:0] modPresent,
  output logic [7:0]          rdByte,
  output logic [NUM_FANS-1:0] pwmOut,
  output logic [NUM_FANS-1:0] mainFanEn,
  output logic [NUM_MODS-1:0] modFanEn
);

  localparam int PRE_W  = (PWM_PRESCALE > 1) ? $clog2(PWM_PRESCALE) : 1;
  localparam int WIN_W  = (TACH_WINDOW > 1) ? $clog2(TACH_WINDOW) : 1;
  localparam int STEP_W = $clog2(PWM_STEPS);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PWM_PRESCALE - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(TACH_WINDOW - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(PWM_STEPS - 1);

  logic [7:0]                ctrlReg;
  logic [PRE_W-1:0]          preCnt;
  logic [STEP_W-1:0]         stepCnt;
  logic [WIN_W-1:0]          winCnt;
  logic                      windowEnd;
  logic [NUM_FANS-1:0][7:0]  rpsVec;
  logic [1:0]                rpsIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= CTRL_RESET;
    else if (cmd.wrStb && cmd.regSel == 2'd0) ctrlReg <= cmd.wrByte;
  end

  // shared PWM timebase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt  <= '0;
      stepCnt <= (stepCnt == STEP_LAST) ? '0 : stepCnt + STEP_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // shared measurement window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else winCnt <= windowEnd ? '0 : winCnt + WIN_W'(1);
  end
  assign windowEnd = (winCnt == WIN_LAST);

  for (genvar f = 0; f < NUM_FANS; f++) begin : gen_fan
    logic [7:0] dutyVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dutyVal <= DUTY_RESET;
      else if (cmd.wrStb && cmd.regSel == 2'(f + 1))
        dutyVal <= (cmd.wrByte > DUTY_FULL) ? DUTY_FULL : cmd.wrByte;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pwmOut[f] <= 1'b0;
      else pwmOut[f] <= (8'(stepCnt) < dutyVal);
    end

    fan_tach_meter u_meter (
      .clk      (clk),
      .rstN     (rstN),
      .tachIn   (tachIn[f]),
      .windowEnd(windowEnd),
      .rps      (rpsVec[f])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainFanEn <= '0;
      modFanEn  <= '0;
    end else begin
      mainFanEn <= ctrlReg[NUM_FANS-1:0];
      modFanEn  <= ctrlReg[NUM_FANS +: NUM_MODS] & modPresent;
    end
  end

  assign rpsIdx = cmd.regSel - 2'd1;

  always_comb begin
    rdByte = ctrlReg;
    if (cmd.regSel != 2'd0) rdByte = rpsVec[rpsIdx];
  end

endmodule

// File: rtl/fan_ctrl_target.sv
module fan_ctrl_target
  import fanreg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR  = 7'h74,
  parameter int         PWM_PRESCALE = 250,
  parameter int         TACH_WINDOW  = 25_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaDriveLow,
  input  logic [NUM_FANS-1:0] tachIn,
  input  logic [NUM_MODS-1:0] modPresent,
  output logic [NUM_FANS-1:0] pwmOut,
  output logic [NUM_FANS-1:0] mainFanEn,
  output logic [NUM_MODS-1:0] modFanEn
);

  regCmd_t    cmd;
  logic [7:0] rdByte;

  fan_i2c_ctrl #(.TARGET_ADDR(TARGET_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rdByte     (rdByte),
    .cmd        (cmd),
    .sdaDriveLow(sdaDriveLow)
  );

  fan_datapath #(
    .PWM_PRESCALE(PWM_PRESCALE),
    .TACH_WINDOW (TACH_WINDOW)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .tachIn    (tachIn),
    .modPresent(modPresent),
    .rdByte    (rdByte),
    .pwmOut    (pwmOut),
    .mainFanEn (mainFanEn),
    .modFanEn  (modFanEn)
  );

endmodule

// File: rtl/fan_ctrl_target_checker.sv
module fan_ctrl_target_checker
  import fanreg_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                sclIn,
  input logic                sdaDriveLow,
  input regCmd_t             cmd,
  input logic [7:0]          rdByte,
  input logic [NUM_FANS-1:0] mainFanEn,
  input logic [NUM_MODS-1:0] modFanEn,
  input logic [NUM_MODS-1:0] modPresent
);

  // data line only moves while the bus clock is low
  assert_sda_quiet_scl_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaDriveLow));

  // a write strobe lasts a single cycle
  assert_wr_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrStb |=> !cmd.wrStb);

  // a control write is visible on the read path in the next cycle
  assert_ctrl_readback_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrStb && cmd.regSel == 2'd0) |=> (rdByte == $past(cmd.wrByte)));

  // main fan enables pick up the control write two cycles later
  assert_main_enable_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrStb && cmd.regSel == 2'd0) |=> ##1 (mainFanEn == $past(cmd.wrByte[NUM_FANS-1:0], 2)));

  // no module fan runs without its module present
  assert_mod_gate_present_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((modFanEn & ~$past(modPresent)) == '0));

endmodule

bind fan_ctrl_target fan_ctrl_target_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaDriveLow(sdaDriveLow),
  .cmd        (cmd),
  .rdByte     (rdByte),
  .mainFanEn  (mainFanEn),
  .modFanEn   (modFanEn),
  .modPresent (modPresent)
);

// File: tb/fan_ctrl_target_bench.sv
`timescale 1ns/1ps
module fan_ctrl_target_bench;
  import fanreg_pkg::*;

  localparam int         PRE  = 2;
  localparam int         WIN  = 2000;
  localparam int         HP   = 12;
  localparam int         Q    = 6;
  localparam logic [6:0] ADDR = 7'h74;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  logic sdaBus;
  logic [NUM_FANS-1:0] tachIn = '0;
  logic [NUM_MODS-1:0] modPresent = '1;
  logic [NUM_FANS-1:0] pwmOut, mainFanEn;
  logic [NUM_MODS-1:0] modFanEn;

  int nTests = 0;
  int nFails = 0;
  bit done = 1'b0;
  int tachPer [NUM_FANS] = '{0, 0, 0};
  int tachCnt [NUM_FANS] = '{0, 0, 0};

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~sdaDriveLow;

  fan_ctrl_target #(
    .TARGET_ADDR (ADDR),
    .PWM_PRESCALE(PRE),
    .TACH_WINDOW (WIN)
  ) u_fan_ctrl_target (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .sdaDriveLow(sdaDriveLow),
    .tachIn     (tachIn),
    .modPresent (modPresent),
    .pwmOut     (pwmOut),
    .mainFanEn  (mainFanEn),
    .modFanEn   (modFanEn)
  );

  // tachometer pulse trains
  always @(negedge clk) begin
    for (int f = 0; f < NUM_FANS; f++) begin
      if (tachPer[f] == 0) begin
        tachIn[f] <= 1'b0;
      end else begin
        tachCnt[f] = (tachCnt[f] + 1) % tachPer[f];
        tachIn[f] <= (tachCnt[f] < tachPer[f] / 2);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; cyc(Q);
    sclM = 1'b1; cyc(HP);
    sdaM = 1'b0; cyc(HP);
    sclM = 1'b0; cyc(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; cyc(Q);
    sclM = 1'b1; cyc(HP);
    sdaM = 1'b1; cyc(HP);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; cyc(Q);
    sclM = 1'b1; cyc(HP);
    sclM = 1'b0; cyc(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; cyc(Q);
    sclM = 1'b1; cyc(HP / 2);
    b = sdaBus; cyc(HP / 2);
    sclM = 1'b0; cyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(!giveAck);
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                          output bit ackA, output bit ackR, output bit ackD);
    busStart();
    sendByte({a, 1'b0}, ackA);
    sendByte(r, ackR);
    sendByte(d, ackD);
    busStop();
  endtask

  task automatic regRead(input logic [7:0] r, input bit twoBytes,
                         output logic [7:0] d0, output logic [7:0] d1, output bit ackAll);
    bit a0, a1, a2;
    busStart();
    sendByte({ADDR, 1'b0}, a0);
    sendByte(r, a1);
    busStart();
    sendByte({ADDR, 1'b1}, a2);
    d1 = '0;
    if (twoBytes) begin
      recvByte(1'b1, d0);
      recvByte(1'b0, d1);
    end else begin
      recvByte(1'b0, d0);
    end
    busStop();
    ackAll = a0 && a1 && a2;
  endtask

  task automatic pwmHigh(input int f, output int hi);
    cyc(PWM_STEPS * PRE);
    hi = 0;
    for (int i = 0; i < PWM_STEPS * PRE; i++) begin
      cyc(1);
      hi += int'(pwmOut[f]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    bit aA, aR, aD, okAll;
    logic [7:0] d0, d1;
    int hi;
    int duties [11] = '{0, 1, 2, 49, 50, 98, 99, 100, 101, 150, 255};

    cyc(5);
    rstN = 1'b1;
    cyc(5);

    // R3 reset state
    checkEq("R3 mainFanEn reset", mainFanEn, 7);
    checkEq("R9 modFanEn reset all present", modFanEn, 31);
    checkEq("R1 idle no drive", sdaDriveLow, 0);
    for (int f = 0; f < NUM_FANS; f++) begin
      pwmHigh(f, hi);
      checkEq("R3 reset duty", hi, 30 * PRE);
    end
    regRead(8'd0, 1'b0, d0, d1, okAll);
    checkEq("R1 acks on own address", okAll, 1);
    checkEq("R3 control reset", d0, 8'hFF);

    // R5 / R6 duty sweep on fan 1
    foreach (duties[k]) begin
      regWrite(ADDR, 8'd1, 8'(duties[k]), aA, aR, aD);
      checkEq("R5 duty write ack", aA && aR && aD, 1);
      pwmHigh(0, hi);
      if (duties[k] > 100) checkEq("R6 duty clamp", hi, 100 * PRE);
      else checkEq("R5 duty high time", hi, duties[k] * PRE);
    end
    pwmHigh(1, hi); checkEq("R5 fan2 untouched", hi, 30 * PRE);
    pwmHigh(2, hi); checkEq("R5 fan3 untouched", hi, 30 * PRE);
    regWrite(ADDR, 8'd2, 8'd77, aA, aR, aD);
    regWrite(ADDR, 8'd3, 8'd0, aA, aR, aD);
    pwmHigh(1, hi); checkEq("R5 fan2 duty", hi, 77 * PRE);
    pwmHigh(2, hi); checkEq("R5 fan3 duty", hi, 0);
    pwmHigh(0, hi); checkEq("R6 fan1 still clamped", hi, 100 * PRE);

    // R2 out of range index
    regWrite(ADDR, 8'd4, 8'h00, aA, aR, aD);
    checkEq("R2 index 4 nack", aR, 0);
    regWrite(ADDR, 8'hFF, 8'h00, aA, aR, aD);
    checkEq("R2 index 255 nack", aR, 0);
    regRead(8'd0, 1'b0, d0, d1, okAll);
    checkEq("R2 control unchanged", d0, 8'hFF);

    // R1 foreign addresses
    regWrite(7'h75, 8'd0, 8'h00, aA, aR, aD);
    checkEq("R1 addr 0x75 nack", aA, 0);
    regWrite(7'h34, 8'd1, 8'd10, aA, aR, aD);
    checkEq("R1 addr 0x34 nack", aA, 0);
    regRead(8'd0, 1'b0, d0, d1, okAll);
    checkEq("R1 control unchanged", d0, 8'hFF);
    pwmHigh(0, hi); checkEq("R1 duty unchanged", hi, 100 * PRE);

    // R4 / R8 / R9 control sweep crossed with presence
    for (int h = 0; h < 32; h++) begin
      logic [7:0] v;
      v = {5'(h), 3'(h) ^ 3'b101};
      regWrite(ADDR, 8'd0, v, aA, aR, aD);
      regRead(8'd0, 1'b0, d0, d1, okAll);
      checkEq("R4 control readback", d0, v);
      checkEq("R8 main enables", mainFanEn, v[2:0]);
      for (int p = 0; p < 32; p++) begin
        modPresent = 5'(p);
        cyc(3);
        checkEq("R9 module enable gate", modFanEn, v[7:3] & 5'(p));
      end
    end

    // R7 tachometer counts
    tachPer[0] = 20; tachPer[1] = 8; tachPer[2] = 0;
    cyc(2 * WIN + 50);
    regRead(8'd1, 1'b0, d0, d1, okAll); checkEq("R7 fan1 rps", d0, 100);
    regRead(8'd2, 1'b0, d0, d1, okAll); checkEq("R7 fan2 rps", d0, 250);
    regRead(8'd3, 1'b0, d0, d1, okAll); checkEq("R7 fan3 rps", d0, 0);
    tachPer[0] = 4; tachPer[1] = 40; tachPer[2] = 10;
    cyc(2 * WIN + 50);
    regRead(8'd1, 1'b0, d0, d1, okAll); checkEq("R7 fan1 saturates", d0, 255);
    regRead(8'd3, 1'b0, d0, d1, okAll); checkEq("R7 fan3 rps", d0, 200);
    regRead(8'd2, 1'b1, d0, d1, okAll);
    checkEq("R10 first byte", d0, 50);
    checkEq("R10 repeated byte", d1, 50);
    checkEq("R10 acks", okAll, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule